// File: doc/BRIEF.md
# Receive-Side Software Flow Control Detector

This block sits between a UART receiver and its receive FIFO. Each received byte is compared against four programmable control characters: two resume codes and two pause codes. The result sets whether the local transmitter may send. Bytes that are recognised as flow-control characters are removed from the stream. All other bytes are forwarded to the FIFO through a one-cycle write strobe.

A 2-bit mode input selects the characters that are matched. The options are: no matching, the first pair, the second pair, or both pairs as two-byte sequences. Two options can be enabled on top of the mode:
- **Resume on any byte.** Any byte received while paused restarts transmission.
- **Special-character detect.** A byte equal to the second pause code raises a sticky interrupt flag without pausing. A read of the interrupt-identification register clears the flag.

Top module: `uart_swfc_rx`

## Requirements
- R1: After reset the outputs are as follows: `tx_allow` is 1, `fifo_wr` is 0 and `xoff_irq` is 0.
- R2: In mode 2'b10 the detector matches `xon_a`/`xoff_a`. In mode 2'b01 it matches `xon_b`/`xoff_b`. A matching pause byte drives `tx_allow` to 0 and a matching resume byte drives it to 1, at the clock edge that samples the byte.
- R3: A byte that a mode recognises as a flow-control character is not written to the FIFO. Every other valid byte produces `fifo_wr`=1 with `fifo_data` equal to the byte, one cycle after it is sampled.
- R4: In mode 2'b11 the detector matches two-byte sequences. `xoff_a` followed by `xoff_b` pauses transmission, and `xon_a` followed by `xon_b` resumes it. The two bytes must be consecutive valid bytes. Idle cycles between them do not break the sequence.
- R5: In mode 2'b11, suppose the byte after a first half is not the expected second half. The first half is then discarded and is not written. The new byte is treated as a first half if it equals `xon_a` or `xoff_a`, and otherwise it is written as data.
- R6: In mode 2'b00 no byte is matched. Every valid byte is written, and `tx_allow` is 1 from the cycle after the mode is seen.
- R7: Suppose `any_resume_en` is 1, the mode is nonzero and transmission is paused. Then any valid byte resumes transmission and is written to the FIFO, even if it is a flow-control character.
- R8: Special-character detect applies when `spec_det_en` is 1 and the mode is 2'b00 or 2'b10. A byte equal to `xoff_b` then has the following effects:
  - it sets `xoff_irq`;
  - it is written to the FIFO;
  - it leaves `tx_allow` unchanged;
  - it does not trigger resume-on-any.
- R9: `xoff_irq` stays set until a cycle with `iir_read`=1, which clears it. If a special character arrives in the same cycle as the read, the flag stays set.
- R10: `fifo_wr` is 1 only in the cycle after a cycle with `rx_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | W | Received byte |
| rx_mode | input | 2 | Match set: 00 none, 10 first pair, 01 second pair, 11 sequences |
| any_resume_en | input | 1 | Resume on any byte while paused |
| spec_det_en | input | 1 | Special-character detect enable |
| xon_a | input | W | First resume code |
| xon_b | input | W | Second resume code |
| xoff_a | input | W | First pause code |
| xoff_b | input | W | Second pause code, also the special character |
| iir_read | input | 1 | Interrupt-identification read strobe |
| tx_allow | output | 1 | Transmitter may send |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | W | Byte to write |
| xoff_irq | output | 1 | Sticky special-character interrupt |

## Verification
Every output of this block is a register. A byte sampled at a clock edge therefore shows its effect on `tx_allow`, `fifo_wr`/`fifo_data` and `xoff_irq` exactly one edge later, and an `iir_read` pulse clears the flag on the same schedule. The bench drives each vector on a falling edge and compares the outputs on the next falling edge against a reference model, which it advances once per vector. In mode 11 the first half of a sequence produces no output of its own. Its effect is checked one byte later, on the output for the second byte.

// File: rtl/uart_swfc_rx.sv
module uart_swfc_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_byte,
  input  logic [1:0]   rx_mode,
  input  logic         any_resume_en,
  input  logic         spec_det_en,
  input  logic [W-1:0] xon_a,
  input  logic [W-1:0] xon_b,
  input  logic [W-1:0] xoff_a,
  input  logic [W-1:0] xoff_b,
  input  logic         iir_read,
  output logic         tx_allow,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_data,
  output logic         xoff_irq
);

  typedef enum logic [1:0] {PEND_NONE, PEND_XON, PEND_XOFF} pend_t;

  localparam logic [1:0] MODE_OFF  = 2'b00;
  localparam logic [1:0] MODE_SEQ  = 2'b11;

  logic         halted_q, halted_d;
  pend_t        pend_q, pend_d;
  logic         wr_d;
  logic         irq_q;
  logic         wr_q;
  logic [W-1:0] data_q;

  wire          single  = (rx_mode == 2'b10) || (rx_mode == 2'b01);
  wire [W-1:0]  on_code  = rx_mode[1] ? xon_a  : xon_b;
  wire [W-1:0]  off_code = rx_mode[1] ? xoff_a : xoff_b;
  wire          spec_hit = rx_valid && spec_det_en && !rx_mode[0] && (rx_byte == xoff_b);
  wire          any_hit  = rx_valid && any_resume_en && halted_q && (rx_mode != MODE_OFF);

  always_comb begin
    halted_d = halted_q;
    pend_d   = (rx_mode == MODE_SEQ) ? pend_q : PEND_NONE;
    wr_d     = 1'b0;
    if (rx_mode == MODE_OFF) halted_d = 1'b0;
    if (rx_valid) begin
      if (spec_hit) begin
        wr_d = 1'b1;
      end else if (any_hit) begin
        halted_d = 1'b0;
        pend_d   = PEND_NONE;
        wr_d     = 1'b1;
      end else if (single) begin
        if (rx_byte == off_code)     halted_d = 1'b1;
        else if (rx_byte == on_code) halted_d = 1'b0;
        else                         wr_d = 1'b1;
      end else if (rx_mode == MODE_SEQ) begin
        if (pend_q == PEND_XOFF && rx_byte == xoff_b) begin
          halted_d = 1'b1;
          pend_d   = PEND_NONE;
        end else if (pend_q == PEND_XON && rx_byte == xon_b) begin
          halted_d = 1'b0;
          pend_d   = PEND_NONE;
        end else if (rx_byte == xoff_a) begin
          pend_d = PEND_XOFF;
        end else if (rx_byte == xon_a) begin
          pend_d = PEND_XON;
        end else begin
          pend_d = PEND_NONE;
          wr_d   = 1'b1;
        end
      end else begin
        wr_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      pend_q   <= PEND_NONE;
      irq_q    <= 1'b0;
      wr_q     <= 1'b0;
      data_q   <= '0;
    end else begin
      halted_q <= halted_d;
      pend_q   <= pend_d;
      wr_q     <= wr_d;
      if (wr_d) data_q <= rx_byte;
      if (spec_hit)      irq_q <= 1'b1;
      else if (iir_read) irq_q <= 1'b0;
    end
  end

  assign tx_allow  = !halted_q;
  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;
  assign xoff_irq  = irq_q;

  p_mode_off_allows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode == MODE_OFF |=> tx_allow);

  p_spec_sets_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    spec_hit |=> xoff_irq && fifo_wr);

  p_spec_no_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_hit && rx_mode == 2'b10) |=> $stable(tx_allow));

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_read && !spec_hit) |=> !xoff_irq);

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xoff_irq && !iir_read) |=> xoff_irq);

  p_wr_needs_byte_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !fifo_wr);

endmodule

// File: tb/test_uart_swfc_rx.sv
module test_uart_swfc_rx;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [W-1:0] rx_byte = '0;
  logic [1:0] rx_mode = 2'b00;
  logic any_resume_en = 1'b0, spec_det_en = 1'b0, iir_read = 1'b0;
  logic [W-1:0] xon_a = 8'h11, xon_b = 8'h12, xoff_a = 8'h13, xoff_b = 8'h14;
  logic tx_allow, fifo_wr, xoff_irq;
  logic [W-1:0] fifo_data;

  int vectors = 0;
  int miscompares = 0;

  bit m_halt = 0;
  int m_pend = 0;
  bit m_irq = 0;
  bit e_wr = 0;
  logic [W-1:0] e_data = '0;

  always #5 clk = ~clk;

  uart_swfc_rx #(.W(W)) i_uart_swfc_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_mode(rx_mode), .any_resume_en(any_resume_en), .spec_det_en(spec_det_en),
    .xon_a(xon_a), .xon_b(xon_b), .xoff_a(xoff_a), .xoff_b(xoff_b),
    .iir_read(iir_read), .tx_allow(tx_allow), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .xoff_irq(xoff_irq));

  function automatic bit is_on(input logic [W-1:0] b, input logic [1:0] m);
    return (m == 2'b10) ? (b == xon_a) : (b == xon_b);
  endfunction

  function automatic bit is_off(input logic [W-1:0] b, input logic [1:0] m);
    return (m == 2'b10) ? (b == xoff_a) : (b == xoff_b);
  endfunction

  task automatic model(input bit v, input logic [W-1:0] b, input logic [1:0] m,
                       input bit any, input bit sp, input bit rd);
    bit hit;
    e_wr = 0;
    if (m == 2'b00) m_halt = 0;
    if (m != 2'b11) m_pend = 0;
    hit = v && sp && (m == 2'b00 || m == 2'b10) && b == xoff_b;
    if (v) begin
      if (hit) e_wr = 1;
      else if (any && m_halt && m != 2'b00) begin
        m_halt = 0; m_pend = 0; e_wr = 1;
      end else if (m == 2'b00) e_wr = 1;
      else if (m != 2'b11) begin
        if (is_off(b, m)) m_halt = 1;
        else if (is_on(b, m)) m_halt = 0;
        else e_wr = 1;
      end else begin
        if (m_pend == 2 && b == xoff_b) begin m_halt = 1; m_pend = 0; end
        else if (m_pend == 1 && b == xon_b) begin m_halt = 0; m_pend = 0; end
        else if (b == xoff_a) m_pend = 2;
        else if (b == xon_a) m_pend = 1;
        else begin m_pend = 0; e_wr = 1; end
      end
    end
    if (hit) m_irq = 1;
    else if (rd) m_irq = 0;
    if (e_wr) e_data = b;
  endtask

  task automatic check(input string tag);
    vectors++;
    if (tx_allow !== !m_halt) begin
      miscompares++;
      $display("FAIL %s tx_allow actual %0b expected %0b", tag, tx_allow, !m_halt);
    end
    if (fifo_wr !== e_wr || (e_wr && fifo_data !== e_data)) begin
      miscompares++;
      $display("FAIL %s fifo wr/data actual %0b/%02h expected %0b/%02h",
               tag, fifo_wr, fifo_data, e_wr, e_data);
    end
    if (xoff_irq !== m_irq) begin
      miscompares++;
      $display("FAIL %s xoff_irq actual %0b expected %0b", tag, xoff_irq, m_irq);
    end
  endtask

  task automatic apply(input bit v, input logic [W-1:0] b, input bit rd, input string tag);
    rx_valid = v; rx_byte = b; iir_read = rd;
    model(v, b, rx_mode, any_resume_en, spec_det_en, rd);
    @(negedge clk);
    check(tag);
  endtask

  task automatic cfg(input logic [1:0] m, input bit any, input bit sp);
    rx_mode = m; any_resume_en = any; spec_det_en = sp;
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int r;
    logic [W-1:0] pool [4];
    logic [W-1:0] b;
    r = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // single pair, first set
    cfg(2'b10, 0, 0);
    apply(1, 8'h41, 0, "R3 data mode10");
    apply(1, xoff_a, 0, "R2 R3 xoff_a halts");
    apply(1, 8'h42, 0, "R3 data while halted");
    apply(1, xoff_b, 0, "R2 xoff_b ignored mode10");
    apply(1, xon_a, 0, "R2 R3 xon_a resumes");
    // second pair
    cfg(2'b01, 0, 0);
    apply(1, xoff_a, 0, "R2 xoff_a data mode01");
    apply(1, xoff_b, 0, "R2 xoff_b halts mode01");
    apply(1, xon_b, 0, "R2 xon_b resumes mode01");
    // sequences
    cfg(2'b11, 0, 0);
    apply(1, xoff_a, 0, "R4 first half");
    apply(0, 8'h00, 0, "R4 idle gap");
    apply(1, xoff_b, 0, "R4 xoff pair halts");
    apply(1, xon_a, 0, "R4 xon first half");
    apply(1, 8'h55, 0, "R5 broken sequence data");
    apply(1, xon_a, 0, "R5 first half again");
    apply(1, xoff_a, 0, "R5 new first half");
    apply(1, xoff_b, 0, "R5 halts via new pair");
    apply(1, xon_b, 0, "R4 lone second half is data");
    apply(1, xon_a, 0, "R4 xon first");
    apply(1, xon_b, 0, "R4 xon pair resumes");
    // resume-on-any
    cfg(2'b10, 1, 0);
    apply(1, xoff_a, 0, "R7 halt");
    apply(1, xoff_a, 0, "R7 flow byte resumes and is written");
    // special character
    cfg(2'b10, 0, 1);
    apply(1, xoff_b, 0, "R8 special sets irq no halt");
    apply(1, 8'h66, 0, "R9 irq sticky");
    apply(1, xoff_b, 1, "R9 set wins over read");
    apply(0, 8'h00, 1, "R9 read clears");
    cfg(2'b10, 1, 1);
    apply(1, xoff_a, 0, "R8 halt before special");
    apply(1, xoff_b, 0, "R8 special does not resume");
    apply(1, 8'h77, 1, "R7 other byte resumes");
    // mode off
    cfg(2'b10, 0, 0);
    apply(1, xoff_a, 0, "R6 halt before off");
    cfg(2'b00, 0, 0);
    apply(0, 8'h00, 0, "R6 off forces allow");
    apply(1, xon_a, 0, "R6 control byte written in off");
    apply(0, 8'h00, 0, "R10 idle no write");

    for (int i = 0; i < 4000; i++) begin
      if (i % 40 == 0) begin
        logic [1:0] m;
        m = 2'($urandom);
        cfg(m, 1'($urandom), (m[0] == 1'b0) ? 1'($urandom) : 1'b0);
      end
      pool[0] = xon_a; pool[1] = xon_b; pool[2] = xoff_a; pool[3] = xoff_b;
      b = ($urandom % 3 == 0) ? 8'($urandom) : pool[$urandom % 4];
      apply(($urandom % 4) != 0, b, ($urandom % 8) == 0, "R2-mix random R3 R4 R5 R7 R8 R9 R10");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule